// File: doc/BRIEF.md
# Multiplexer-Based Reconfigurable Logic Tile

This block is a tile of fine-grain reconfigurable logic cells. Each cell computes one Boolean function of two variables using only 2:1 multiplexers, and it holds one D-type state bit. Every cell listens only to its four adjacent cells: north, east, south and west. A default 4x4 tile links the cells to each other. Where a cell on the tile border has no adjacent cell, the missing input comes from a boundary input port.

A host configures the tile one cell at a time. It presents a cell address (row times column count plus column) and a write strobe, and the addressed cell captures an 11-bit configuration word. The same address also drives a combinational readback path. That path returns the addressed cell's configuration and its present state bit. A global `tick` input is the clock enable of every state bit, so the host can freeze the array while it loads it. The `cell_obs` vector shows one output per cell, either the combinational function result or the stored state.

Only stored state crosses between cells. A change on a cell's function therefore reaches its neighbours one clock later. No chain of cells can close a combinational loop.

Top module: `lc_block`

## Requirements
- R1: After reset every cell's configuration word and state bit are zero, so readback returns zero at every address.
- R2: With `host_we` high at a clock edge, `host_wdata` is stored as the configuration of the cell at `host_addr` (cell index = row*COLS + col, row 0 at the north edge, column 0 at the west edge), and no other cell's configuration changes.
- R3: `host_rdata` combinationally returns the addressed cell's state in bit 11 and its configuration in bits 10:0, in the same cycle the address is applied.
- R4: The configuration fields are: bits 1:0 select the neighbour that drives the multiplexer select; bits 4:2 and bit 5 give the source and inversion of the leg taken when the select is 0; bits 8:6 and bit 9 give the source and inversion of the leg taken when the select is 1. With the neighbour codes 0=north, 1=east, 2=south, 3=west, all sixteen functions of two neighbours can be set up.
- R5: Configuration bit 10 chooses the cell's `cell_obs` output: 0 shows the combinational function result, 1 shows the stored state bit.
- R6: At a clock edge with `tick` high, every state bit loads its cell's function result. With `tick` low, every state bit holds its value.
- R7: Each cell's neighbour inputs are the state bits of the adjacent cells. A border cell takes its missing neighbour from `bnd_north[col]`, `bnd_south[col]`, `bnd_west[row]` or `bnd_east[row]`.
- R8: Leg source code 4 selects the cell's own state bit. Codes 5, 6 and 7 select constant zero, so with inversion they give constant one.
- R9: If a host write and a tick fall on the same edge, the addressed cell's state loads the result of its old configuration. The new configuration applies from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Clock enable for all cell state bits |
| host_we | input | 1 | Configuration write strobe |
| host_addr | input | 4 | Cell index row*COLS + col |
| host_wdata | input | 11 | Configuration word to store |
| host_rdata | output | 12 | {state bit, configuration word} of the addressed cell |
| bnd_north | input | 4 | North boundary input, one per column |
| bnd_south | input | 4 | South boundary input, one per column |
| bnd_west | input | 4 | West boundary input, one per row |
| bnd_east | input | 4 | East boundary input, one per row |
| cell_obs | output | 16 | Per-cell output, index row*COLS + col |

## Verification
Two functions can land on the same edge: a host write that replaces a cell's configuration, and a tick that loads that cell's state from its configuration. The bench sets a cell to toggle on its own state and reads that state first. It then issues a write of a constant-one configuration on the same edge as a tick. The state must come out inverted, which proves the old configuration was used, and the readback must already show the new word. Only the next tick may drive the state to one. The collision is run twice, once from each state polarity. Around it, randomised configurations evolve under a bench model, and all outputs and readbacks are compared after every edge.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned SRC_W = 3;
  localparam int unsigned CFG_W = 11;
  localparam int unsigned NBR_N = 4;

  // neighbour positions inside a cell's neighbour vector
  localparam int unsigned IX_N = 0;
  localparam int unsigned IX_E = 1;
  localparam int unsigned IX_S = 2;
  localparam int unsigned IX_W = 3;

  // leg source code for the cell's own state bit; higher codes are zero
  localparam logic [SRC_W-1:0] SRC_SELF = 3'd4;

  typedef struct packed {
    logic             obs_reg;
    logic             b_inv;
    logic [SRC_W-1:0] b_src;
    logic             a_inv;
    logic [SRC_W-1:0] a_src;
    logic [SEL_W-1:0] sel_src;
  } cell_cfg_t;

endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/lc_mux_fn.sv
module lc_mux_fn
  import lc_pkg::*;
(
  input  logic [NBR_N-1:0] nbr,
  input  logic             self_q,
  input  cell_cfg_t        cfg,
  output logic             fn_out
);

  logic [1:0]       leg;
  logic [SRC_W-1:0] leg_src [2];
  logic             leg_inv [2];
  logic             sel;

  assign leg_src[0] = cfg.a_src;
  assign leg_src[1] = cfg.b_src;
  assign leg_inv[0] = cfg.a_inv;
  assign leg_inv[1] = cfg.b_inv;

  // each leg: source mux followed by a conditional inversion
  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic raw;
    always_comb begin
      if (!leg_src[g][SRC_W-1]) begin
        raw = nbr[leg_src[g][SEL_W-1:0]];
      end else if (leg_src[g] == SRC_SELF) begin
        raw = self_q;
      end else begin
        raw = 1'b0;
      end
      leg[g] = leg_inv[g] ? ~raw : raw;
    end
  end

  assign sel    = nbr[cfg.sel_src];
  assign fn_out = sel ? leg[1] : leg[0];

endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_we,
  input  cell_cfg_t        cfg_wdata,
  input  logic [NBR_N-1:0] nbr,
  output cell_cfg_t        cfg_q,
  output logic             state_q,
  output logic             obs
);

  cell_cfg_t cfg_r;
  cell_cfg_t cfg_d;
  logic      state_r;
  logic      state_d;
  logic      fn;

  lc_mux_fn u_fn (
    .nbr    (nbr),
    .self_q (state_r),
    .cfg    (cfg_r),
    .fn_out (fn)
  );

  always_comb begin
    cfg_d   = cfg_r;
    state_d = state_r;
    if (cfg_we) begin
      cfg_d = cfg_wdata;
    end
    if (tick) begin
      state_d = fn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r   <= '0;
      state_r <= 1'b0;
    end else begin
      cfg_r   <= cfg_d;
      state_r <= state_d;
    end
  end

  assign cfg_q   = cfg_r;
  assign state_q = state_r;
  assign obs     = cfg_r.obs_reg ? state_r : fn;

endmodule

// File: rtl/lc_host_port.sv
module lc_host_port
  import lc_pkg::*;
#(
  parameter int unsigned N_CELLS = 16,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned RD_W   = CFG_W + 1
) (
  input  logic                          host_we,
  input  logic [ADDR_W-1:0]             host_addr,
  input  cell_cfg_t [N_CELLS-1:0]       cfg_all,
  input  logic [N_CELLS-1:0]            state_all,
  output logic [N_CELLS-1:0]            we_vec,
  output logic [RD_W-1:0]               rdata
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_dec
    assign we_vec[i] = host_we && (host_addr == ADDR_W'(i));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (host_addr == ADDR_W'(i)) begin
        rdata = {state_all[i], cfg_all[i]};
      end
    end
  end

endmodule

// File: rtl/lc_block.sv
module lc_block
  import lc_pkg::*;
#(
  parameter int unsigned ROWS        = 4,
  parameter int unsigned COLS        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_CELLS    = ROWS * COLS,
  localparam int unsigned ADDR_W     = $clog2(N_CELLS),
  localparam int unsigned RD_W       = CFG_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [CFG_W-1:0]   host_wdata,
  output logic [RD_W-1:0]    host_rdata,
  input  logic [COLS-1:0]    bnd_north,
  input  logic [COLS-1:0]    bnd_south,
  input  logic [ROWS-1:0]    bnd_west,
  input  logic [ROWS-1:0]    bnd_east,
  output logic [N_CELLS-1:0] cell_obs
);

  logic                    rst_core_n;
  logic [N_CELLS-1:0]      state_vec;
  logic [N_CELLS-1:0]      we_vec;
  cell_cfg_t [N_CELLS-1:0] cfg_all;
  cell_cfg_t               wr_cfg;

  assign wr_cfg = host_wdata;

  lc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  lc_host_port #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_host (
    .host_we   (host_we),
    .host_addr (host_addr),
    .cfg_all   (cfg_all),
    .state_all (state_vec),
    .we_vec    (we_vec),
    .rdata     (host_rdata)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      logic [NBR_N-1:0] nbr;

      if (r == 0) begin : g_n_edge
        assign nbr[IX_N] = bnd_north[c];
      end else begin : g_n_cell
        assign nbr[IX_N] = state_vec[IDX-COLS];
      end

      if (r == ROWS - 1) begin : g_s_edge
        assign nbr[IX_S] = bnd_south[c];
      end else begin : g_s_cell
        assign nbr[IX_S] = state_vec[IDX+COLS];
      end

      if (c == 0) begin : g_w_edge
        assign nbr[IX_W] = bnd_west[r];
      end else begin : g_w_cell
        assign nbr[IX_W] = state_vec[IDX-1];
      end

      if (c == COLS - 1) begin : g_e_edge
        assign nbr[IX_E] = bnd_east[r];
      end else begin : g_e_cell
        assign nbr[IX_E] = state_vec[IDX+1];
      end

      lc_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .tick      (tick),
        .cfg_we    (we_vec[IDX]),
        .cfg_wdata (wr_cfg),
        .nbr       (nbr),
        .cfg_q     (cfg_all[IDX]),
        .state_q   (state_vec[IDX]),
        .obs       (cell_obs[IDX])
      );
    end
  end

endmodule

// File: rtl/lc_block_chk.sv
module lc_block_chk
  import lc_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  localparam int unsigned N_CELLS = ROWS * COLS,
  localparam int unsigned ADDR_W  = $clog2(N_CELLS)
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               tick,
  input logic               host_we,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [CFG_W-1:0]   host_wdata,
  input logic [CFG_W:0]     host_rdata,
  input logic [N_CELLS-1:0] cell_obs,
  input logic [N_CELLS-1:0] state_vec
);

  // R6: without tick no state bit moves, whatever the host does
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tick |=> $stable(state_vec));

  // R2: a write shows up in readback at the same address one edge later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_core_n)
    host_we |=> (host_addr != $past(host_addr)) ||
                (host_rdata[CFG_W-1:0] == $past(host_wdata)));

  // R3: readback state bit matches the addressed cell's register
  a_r3_readback_state: assert property (@(posedge clk) disable iff (!rst_core_n)
    host_rdata[CFG_W] == state_vec[host_addr]);

  // R5: registered observation mode shows the stored bit
  a_r5_obs_registered: assert property (@(posedge clk) disable iff (!rst_core_n)
    host_rdata[CFG_W-1] |-> (cell_obs[host_addr] == host_rdata[CFG_W]));

  // R6: a tick stores what the combinational observation showed
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && !host_rdata[CFG_W-1]) |=>
      (host_addr != $past(host_addr)) ||
      (host_rdata[CFG_W] == $past(cell_obs[host_addr])));

endmodule

bind lc_block lc_block_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .tick       (tick),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .cell_obs   (cell_obs),
  .state_vec  (state_vec)
);

// File: tb/test_lc_block.sv
`timescale 1ns/1ps
module test_lc_block;

  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        host_we;
  logic [3:0]  host_addr;
  logic [10:0] host_wdata;
  logic [11:0] host_rdata;
  logic [3:0]  bnd_n, bnd_s, bnd_w, bnd_e;
  logic [15:0] cell_obs;

  logic [10:0] exp_cfg [NC];
  logic [15:0] exp_q;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lc_block i_lc_block (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bnd_north(bnd_n), .bnd_south(bnd_s), .bnd_west(bnd_w), .bnd_east(bnd_e),
    .cell_obs(cell_obs)
  );

  function automatic logic m_nbr(int i, int d);
    int r = i / 4;
    int c = i % 4;
    case (d)
      0:       return (r == 0) ? bnd_n[c] : exp_q[i-4];
      1:       return (c == 3) ? bnd_e[r] : exp_q[i+1];
      2:       return (r == 3) ? bnd_s[c] : exp_q[i+4];
      default: return (c == 0) ? bnd_w[r] : exp_q[i-1];
    endcase
  endfunction

  function automatic logic m_src(int i, logic [2:0] code);
    if (code < 3'd4) return m_nbr(i, int'(code));
    if (code == 3'd4) return exp_q[i];
    return 1'b0;
  endfunction

  function automatic logic m_fn(int i);
    logic [10:0] k = exp_cfg[i];
    logic a = m_src(i, k[4:2]) ^ k[5];
    logic b = m_src(i, k[8:6]) ^ k[9];
    return m_nbr(i, int'(k[1:0])) ? b : a;
  endfunction

  function automatic logic m_obs(int i);
    return exp_cfg[i][10] ? exp_q[i] : m_fn(i);
  endfunction

  task automatic chk(input string req, input string what, input logic [11:0] act,
                     input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit we, input int addr, input logic [10:0] data);
    logic [15:0] nq;
    @(negedge clk);
    tick = t; host_we = we; host_addr = 4'(addr); host_wdata = data;
    #2;
    for (int i = 0; i < NC; i++) nq[i] = t ? m_fn(i) : exp_q[i];
    @(posedge clk);
    exp_q = nq;
    if (we) exp_cfg[addr] = data;
    #5;
    tick = 1'b0; host_we = 1'b0;
    #1;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NC; i++) begin
      host_addr = 4'(i);
      #0.5;
      chk(req, $sformatf("obs[%0d]", i), {11'd0, cell_obs[i]}, {11'd0, m_obs(i)});
      chk(req, $sformatf("rdata[%0d]", i), host_rdata, {exp_q[i], exp_cfg[i]});
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [10:0] tog_cfg;
    logic [10:0] one_cfg;
    logic        s;
    rst_n = 1'b0; tick = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    bnd_n = '0; bnd_s = '0; bnd_w = '0; bnd_e = '0;
    for (int i = 0; i < NC; i++) exp_cfg[i] = '0;
    exp_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #6;
    check_all("R1");

    // R2 R3: distinct word per cell, no ticks
    for (int i = 0; i < NC; i++) step(0, 1, i, 11'((i * 677 + 19) & 11'h7ff));
    check_all("R2");
    step(0, 1, 6, 11'h5a3);
    check_all("R3");

    // R6 R7 R8: let random configurations evolve with changing boundaries
    for (int n = 0; n < 24; n++) begin
      bnd_n = 4'(n * 5 + 1); bnd_s = 4'(n * 3); bnd_w = 4'(n ^ 9); bnd_e = 4'(~n);
      step(1, 1, (n * 7) % NC, 11'((n * 1213 + 301) & 11'h7ff));
      check_all("R6");
    end
    for (int n = 0; n < 3; n++) begin
      step(0, 0, 0, '0);
      check_all("R6 hold");
    end

    // R4: all sixteen functions of north (x) and west (y) on cell 0
    for (int t = 0; t < 16; t++) begin
      logic [3:0] tt = 4'(t);
      logic [2:0] as = (tt[0] == tt[1]) ? 3'd5 : 3'd3;
      logic [2:0] bs = (tt[2] == tt[3]) ? 3'd5 : 3'd3;
      step(0, 1, 0, {1'b0, tt[2], bs, tt[0], as, 2'd0});
      for (int xy = 0; xy < 4; xy++) begin
        bnd_n[0] = xy[1];
        bnd_w[0] = xy[0];
        #1;
        chk("R4", $sformatf("fn %0d xy %0d", t, xy), {11'd0, cell_obs[0]}, {11'd0, tt[xy]});
      end
    end

    // R7: preload a state pattern, then make every cell pass one direction
    for (int i = 0; i < NC; i++) begin
      logic [15:0] pat = 16'hA5C3;
      step(0, 1, i, {1'b0, pat[i], 3'd5, pat[i], 3'd5, 2'd0});
    end
    step(1, 0, 0, '0);
    bnd_n = 4'h6; bnd_s = 4'h9; bnd_w = 4'h3; bnd_e = 4'hc;
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < NC; i++) step(0, 1, i, {1'b0, 1'b0, 3'(d), 1'b0, 3'(d), 2'(d)});
      check_all("R7");
    end

    // R8: own-state feedback toggles; codes 6 and 7 read zero
    tog_cfg = {1'b1, 1'b1, 3'd4, 1'b1, 3'd4, 2'd0};
    one_cfg = {1'b1, 1'b1, 3'd5, 1'b1, 3'd5, 2'd0};
    step(0, 1, 10, tog_cfg);
    step(0, 1, 11, {1'b0, 1'b0, 3'd7, 1'b0, 3'd6, 2'd1});
    for (int n = 0; n < 4; n++) begin
      host_addr = 4'd10; #0.5;
      s = host_rdata[11];
      step(1, 0, 0, '0);
      host_addr = 4'd10; #0.5;
      chk("R8", "toggle state", {11'd0, host_rdata[11]}, {11'd0, ~s});
      chk("R5", "registered obs", {11'd0, cell_obs[10]}, {11'd0, ~s});
      chk("R8", "constant zero", {11'd0, cell_obs[11]}, 12'd0);
    end

    // R9: write and tick on the same edge, both state phases
    for (int n = 0; n < 2; n++) begin
      step(0, 1, 10, tog_cfg);
      if (n == 1) step(1, 0, 0, '0);
      host_addr = 4'd10; #0.5;
      s = host_rdata[11];
      step(1, 1, 10, one_cfg);
      host_addr = 4'd10; #0.5;
      chk("R9", "collision edge", host_rdata, {~s, one_cfg});
      step(1, 0, 0, '0);
      host_addr = 4'd10; #0.5;
      chk("R9", "next edge", host_rdata, {1'b1, one_cfg});
      check_all("R9");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule